// File: doc/BRIEF.md
# High-Radix Montgomery Modular Multiplier

This block is the multiply and square engine of a prime-field elliptic-curve arithmetic unit. It returns A·B·R⁻¹ mod p for an odd modulus p. Here R = 2^(K·D), with D = ceil(N/K). N is the operand width and K is the number of multiplier bits handled in each iteration. The surrounding arithmetic controller keeps its values in the Montgomery domain, so the R⁻¹ factor cancels across a chain of operations. Squaring uses the same path: the caller presents the same value on both operand inputs.

The operand B is consumed one K-bit digit per clock, least significant digit first. The caller supplies a one-digit precomputed constant, −p⁻¹ mod 2^K. With it, the quotient digit of each iteration is a K×K product of two low digits and needs no division or trial step. Each iteration adds the digit product and the quotient multiple of p to the accumulator and then drops one digit by a plain shift. After D iterations the accumulator is below 2p, and one conditional subtraction of p brings it below p.

The handshake is start, busy and done. A start that arrives while idle captures the operands, the modulus and the constant. done pulses once when the result is ready. The result stays on its output until the next accepted start.

Top module: `mont_mul_hr`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, busy and done are 0 and result is 0.
- R2: For odd p and operands below p, result equals A·B·2^(−K·D) mod p, where D = ceil(N/K). minv_dig must carry −p⁻¹ mod 2^K.
- R3: Every result delivered with done is strictly below p. This includes moduli with all bits set, small moduli, and operands equal to 0 or to p−1.
- R4: Presenting the same value on op_a and op_b yields the Montgomery square A·A·2^(−K·D) mod p.
- R5: done is high for exactly one cycle. It rises D+1 clock edges after the edge that accepted start.
- R6: busy is 1 from the cycle after an accepted start until the cycle in which done is 1. In that cycle busy is 0.
- R7: A start pulse, or any change on op_a, op_b, modulus or minv_dig, while busy is 1 has no effect on the result or on the latency of the operation in progress.
- R8: Without an accepted start, result keeps its value for any number of cycles after done, whatever the data inputs do.
- R9: Operands at or above p give an unspecified value, but the handshake still completes with the same latency as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an operation; accepted only while busy is 0 |
| op_a | input | N | Multiplicand A (below p) |
| op_b | input | N | Multiplier B (below p), consumed K bits per cycle |
| modulus | input | N | Odd modulus p |
| minv_dig | input | K | Precomputed digit −p⁻¹ mod 2^K |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| result | output | N | A·B·R⁻¹ mod p, held until the next accepted start |

## Verification
The hardest state to reach from the ports is an accumulator that is already at or above p after the last iteration, so that the final subtraction must fire, right next to cases where it must not. Random operands reach this only part of the time. Directed cases push it harder: a modulus with all bits set, a modulus of 3, operands of p−1, squaring of p−1, and zero. Every result is compared against a bit-serial reference model and also checked to be below p. A second hard case is a start that arrives mid-operation with different operands. The bench raises start during busy with inverted data and checks that the original result and the latency are unchanged.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    MM_IDLE = 2'd0,
    MM_RUN  = 2'd1,
    MM_FIN  = 2'd2
  } mm_state_e;
endpackage

// File: rtl/mm_qsel.sv
// Quotient digit: low digit of (acc + digit product) times the
// precomputed digit -p^-1 mod 2^K, kept modulo 2^K.
module mm_qsel #(
  parameter int K = 4
) (
  input  logic [K-1:0] acc_lo,
  input  logic [K-1:0] prod_lo,
  input  logic [K-1:0] minv,
  output logic [K-1:0] q
);
  logic [K-1:0]   t_lo;
  logic [2*K-1:0] full;

  always_comb begin
    t_lo = acc_lo + prod_lo;
    full = {{K{1'b0}}, t_lo} * {{K{1'b0}}, minv};
    q    = full[K-1:0];
  end
endmodule

// File: rtl/mm_step.sv
// One iteration: acc' = (acc + d*A + q*p) / 2^K
module mm_step #(
  parameter int N = 192,
  parameter int K = 4
) (
  input  logic [N:0]   acc,
  input  logic [N-1:0] a,
  input  logic [N-1:0] p,
  input  logic [K-1:0] dig,
  input  logic [K-1:0] minv,
  output logic [N:0]   acc_nxt,
  output logic [K-1:0] drop_dig,
  output logic         top_ovf
);
  localparam int SW = N + K + 2;

  logic [N+K-1:0] prod_a;
  logic [N+K-1:0] prod_q;
  logic [K-1:0]   q;
  logic [SW-1:0]  sum;

  assign prod_a = {{K{1'b0}}, a} * {{N{1'b0}}, dig};

  mm_qsel #(.K(K)) qsel_i (
    .acc_lo  (acc[K-1:0]),
    .prod_lo (prod_a[K-1:0]),
    .minv    (minv),
    .q       (q)
  );

  assign prod_q = {{K{1'b0}}, p} * {{N{1'b0}}, q};

  always_comb begin
    sum      = {{(K+1){1'b0}}, acc} + {2'b00, prod_a} + {2'b00, prod_q};
    acc_nxt  = sum[N+K:K];
    drop_dig = sum[K-1:0];
    top_ovf  = sum[SW-1];
  end
endmodule

// File: rtl/mm_fsub.sv
// Final correction: acc in [0, 2p) -> [0, p)
module mm_fsub #(
  parameter int N = 192
) (
  input  logic [N:0]   acc,
  input  logic [N-1:0] p,
  output logic [N-1:0] res,
  output logic         res_hi
);
  logic [N:0] diff;
  logic       ge;

  always_comb begin
    diff   = acc - {1'b0, p};
    ge     = acc >= {1'b0, p};
    res    = ge ? diff[N-1:0] : acc[N-1:0];
    res_hi = ge ? diff[N] : acc[N];
  end
endmodule

// File: rtl/mont_mul_hr.sv
module mont_mul_hr
  import mm_pkg::*;
#(
  parameter int N = 192,
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic [N-1:0] modulus,
  input  logic [K-1:0] minv_dig,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] result
);
  localparam int D  = (N + K - 1) / K;
  localparam int BW = D * K;
  localparam int CW = $clog2(D + 1);

  mm_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [N-1:0]  a_q, a_d, p_q, p_d, res_q, res_d;
  logic [BW-1:0] b_q, b_d;
  logic [K-1:0]  m_q, m_d;
  logic [N:0]    acc_q, acc_d;
  logic          done_q, done_d;
  logic          rng_q, rng_d;   // operands in range: assertion qualifier

  logic          load, run, fin, last;
  logic [N:0]    acc_step;
  logic [K-1:0]  drop_dig;
  logic          top_ovf;
  logic [N-1:0]  res_sub;
  logic          res_hi;

  assign load = (st_q == MM_IDLE) && start;
  assign run  = (st_q == MM_RUN);
  assign fin  = (st_q == MM_FIN);
  assign last = (cnt_q == CW'(D - 1));

  mm_step #(.N(N), .K(K)) step_i (
    .acc      (acc_q),
    .a        (a_q),
    .p        (p_q),
    .dig      (b_q[K-1:0]),
    .minv     (m_q),
    .acc_nxt  (acc_step),
    .drop_dig (drop_dig),
    .top_ovf  (top_ovf)
  );

  mm_fsub #(.N(N)) fsub_i (
    .acc    (acc_q),
    .p      (p_q),
    .res    (res_sub),
    .res_hi (res_hi)
  );

  // next state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    a_d    = a_q;
    b_d    = b_q;
    p_d    = p_q;
    m_d    = m_q;
    acc_d  = acc_q;
    res_d  = res_q;
    rng_d  = rng_q;
    done_d = 1'b0;
    if (load) begin
      st_d  = MM_RUN;
      cnt_d = '0;
      a_d   = op_a;
      b_d   = '0;
      b_d[N-1:0] = op_b;
      p_d   = modulus;
      m_d   = minv_dig;
      acc_d = '0;
      rng_d = modulus[0] && (op_a < modulus) && (op_b < modulus);
    end else if (run) begin
      acc_d = acc_step;
      b_d   = b_q >> K;
      cnt_d = cnt_q + 1'b1;
      if (last) st_d = MM_FIN;
    end else if (fin) begin
      res_d  = res_sub;
      done_d = 1'b1;
      st_d   = MM_IDLE;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MM_IDLE;
      cnt_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      p_q    <= '0;
      m_q    <= '0;
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
      rng_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (load || run) begin
        cnt_q <= cnt_d;
        acc_q <= acc_d;
        b_q   <= b_d;
      end
      if (load) begin
        a_q   <= a_d;
        p_q   <= p_d;
        m_q   <= m_d;
        rng_q <= rng_d;
      end
      if (fin) res_q <= res_d;
    end
  end

  assign busy   = (st_q != MM_IDLE);
  assign done   = done_q;
  assign result = res_q;

  // R2: the chosen quotient clears the dropped digit and the sum fits
  a_r2_digit_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rng_q) |-> (drop_dig == '0 && !top_ovf));
  // R3: accumulator before correction is below 2p, so one subtraction suffices
  a_r3_single_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && rng_q) |-> (!res_hi && res_sub < p_q));
  // R5: done lasts one cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: busy is low while done is shown
  a_r6_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7: a start during a run does not restart the iteration count
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last) |=> (run && cnt_q == $past(cnt_q) + 1'b1));
  // R8: result changes only together with done
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

// File: tb/mont_mul_hr_tb_top.sv
`timescale 1ns/1ps
module mont_mul_hr_tb_top;
  localparam int N   = 192;
  localparam int K   = 4;
  localparam int D   = (N + K - 1) / K;
  localparam int KD  = D * K;
  localparam int LIM = 4 * D + 20;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [N-1:0] op_a, op_b, modulus;
  logic [K-1:0] minv_dig;
  logic         busy, done;
  logic [N-1:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  mont_mul_hr #(.N(N), .K(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .modulus(modulus), .minv_dig(minv_dig), .busy(busy), .done(done),
    .result(result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [K-1:0] minv_of(input logic [N-1:0] p);
    logic [K-1:0] r = '0;
    for (int x = 0; x < (1 << K); x++) begin
      logic [2*K-1:0] pr;
      pr = {{K{1'b0}}, p[K-1:0]} * (2*K)'(x);
      if (pr[K-1:0] == {K{1'b1}}) r = K'(x);
    end
    return r;
  endfunction

  // bit-serial reference: A*B*2^-KD mod p
  function automatic logic [N-1:0] mref(input logic [N-1:0] a, b, p);
    logic [N+1:0]  s = '0;
    logic [N+1:0]  t;
    logic [KD-1:0] bb = '0;
    bb[N-1:0] = b;
    for (int i = 0; i < KD; i++) begin
      t = s + (bb[i] ? {2'b00, a} : '0);
      if (t[0]) t = t + {2'b00, p};
      s = t >> 1;
    end
    if (s >= {2'b00, p}) s = s - {2'b00, p};
    return s[N-1:0];
  endfunction

  function automatic logic [N-1:0] rnd();
    logic [N-1:0] v = '0;
    for (int i = 0; i < (N + 31) / 32; i++) v = (v << 32) | N'($urandom());
    return v;
  endfunction

  // one operation; inj raises start with other data mid-run
  task automatic run_op(input logic [N-1:0] a, b, p, input bit inj,
                        output logic [N-1:0] res, output int lat);
    @(negedge clk);
    op_a = a; op_b = b; modulus = p; minv_dig = minv_of(p); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6", "busy after start", N'(busy), N'(1));
    lat = 0;
    while (!done && lat < LIM) begin
      @(negedge clk);
      lat++;
      if (inj && lat == 5) begin
        start = 1'b1; op_a = ~a; op_b = ~b; minv_dig = ~minv_dig;
      end else if (inj && lat == 6) begin
        start = 1'b0;
      end
    end
    res = result;
    check(busy == 1'b0, "R6", "busy low at done", N'(busy), N'(0));
    @(negedge clk);
    check(done == 1'b0, "R5", "done one cycle", N'(done), N'(0));
  endtask

  task automatic full_case(input logic [N-1:0] a, b, p, input string req);
    logic [N-1:0] res, exp;
    int lat;
    run_op(a, b, p, 1'b0, res, lat);
    exp = mref(a, b, p);
    check(res == exp, req, "value", res, exp);
    check(res < p, "R3", "below modulus", res, p);
    check(lat == D + 1, "R5", "latency", N'(lat), N'(D + 1));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] p, a, b, res, res2, exp;
    int lat;
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; start = 1'b0;
    op_a = '0; op_b = '0; modulus = '0; minv_dig = '0;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && result == '0, "R1", "in reset", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && result == '0, "R1", "after reset", result, '0);

    // directed corners
    p = {N{1'b1}};
    full_case(p - 1, p - 1, p, "R2");
    full_case(p - 1, p - 1, p, "R4");
    full_case('0, p - 1, p, "R2");
    full_case(N'(1), N'(1), p, "R2");
    p = N'(3);
    full_case(N'(2), N'(2), p, "R4");
    full_case(N'(2), N'(1), p, "R3");
    p = {1'b1, {(N-2){1'b0}}, 1'b1};
    full_case(p - 1, N'(1), p, "R3");

    // random operands
    for (int i = 0; i < 40; i++) begin
      p = rnd() | {1'b1, {(N-1){1'b0}}} | N'(1);
      a = rnd() % p;
      b = rnd() % p;
      if (i % 4 == 0) full_case(a, a, p, "R4");
      else full_case(a, b, p, "R2");
    end

    // R7: start with other data while busy
    p = rnd() | N'(1) | {1'b1, {(N-1){1'b0}}};
    a = rnd() % p; b = rnd() % p;
    run_op(a, b, p, 1'b1, res, lat);
    exp = mref(a, b, p);
    check(res == exp, "R7", "start while busy ignored", res, exp);
    check(lat == D + 1, "R7", "latency kept", N'(lat), N'(D + 1));

    // R8: hold without start
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      op_a = rnd(); op_b = rnd(); modulus = rnd(); minv_dig = K'($urandom());
    end
    check(result == exp, "R8", "result held", result, exp);

    // R9: out-of-range operands still complete
    p = rnd() | N'(1);
    p[N-1] = 1'b0;
    run_op({N{1'b1}}, {N{1'b1}}, p, 1'b0, res2, lat);
    check(lat == D + 1, "R9", "latency out of range", N'(lat), N'(D + 1));
    full_case(N'(5) % p, N'(7) % p, p, "R9");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule